// File: doc/BRIEF.md
# Streaming Binary Projection Histogram Accumulator

This block takes a rectangular window of binary pixels, four pixels per clock in raster order, and builds two projection histograms from it. One histogram counts the active pixels in each column. The other counts the active pixels in each row. A register keeps the total number of active pixels in the window. A later stage, such as a median or centroid locator, scans the finished histograms through two synchronous read ports.

The window size is set at run time. The width is given in four-pixel batches, from 1 to 8 (4 to 32 pixels). The height is from 1 to 32 lines. A `start` pulse latches the size. The block then clears every histogram word used by that window and opens the pixel input. The block keeps its own raster position, so the upstream side only has to present batches in order.

The column histogram is split into four banks, one per pixel lane. Bank k at word a holds the count for column 4a+k. Every bank is updated by a read-increment-write loop that can take a new batch every clock. The row histogram is a single memory. Its stored value grows by the number of active lanes, and it is written only when at least one lane is active.

Top module: `proj_hist_acc`

## Requirements
- R1: A `start` pulse in the idle state latches the window size and clears all histogram words the window uses, together with the total. This takes max(batches per line, height) cycles. `ready` first reads high exactly that many clock edges after the edge that sampled `start`, and `total` is zero at that point.
- R2: `ready` stays high until exactly batches × height batches have been accepted. A batch is accepted on an edge where `ready` and `pix_valid` are both high. `ready` is low in the cycle after the last batch is accepted. A cycle with `pix_valid` low does not advance the raster position.
- R3: `done` is high for exactly one cycle. That cycle is the second cycle after the edge that accepts the last batch. At that point every histogram word and `total` already hold the window's final values.
- R4: Bit k of `pix_data` (1 = active) is the pixel in column 4x+k, where x is the batch position in the line. After `done`, setting `col_rd_addr` to c returns the count of active pixels in column c on `col_rd_data` one cycle later.
- R5: After `done`, setting `row_rd_addr` to r returns the count of active pixels in line r on `row_rd_data` one cycle later.
- R6: After `done`, `total` equals the number of active pixels in the window. It never decreases while batches are being accepted.
- R7: Updates to the same histogram word on back-to-back cycles all count. This covers every batch along a line in the row memory, and every line in the column banks when the line is one batch wide.
- R8: No count from an earlier window appears in a later window, whatever the sizes of the two windows.
- R9: Pixels presented while `ready` is low, in the clear phase or in idle, have no effect on any count.
- R10: A `start` pulse while a window is loading is ignored. `ready` stays high and the counts are unaffected.
- R11: After reset, `ready`, `done` and `total` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new window (clear, then load) |
| cfg_line_batches | input | 4 | Window width in four-pixel batches, 1..8 |
| cfg_height | input | 6 | Window height in lines, 1..32 |
| pix_valid | input | 1 | A batch is present on pix_data |
| pix_data | input | 4 | Four binary pixels; bit k is lane k |
| ready | output | 1 | Block accepts batches |
| done | output | 1 | One-cycle pulse: window fully committed |
| total | output | 11 | Active pixel count of the window |
| col_rd_addr | input | 5 | Column index to read |
| col_rd_data | output | 6 | Column count, one cycle after address |
| row_rd_addr | input | 5 | Row index to read |
| row_rd_data | output | 6 | Row count, one cycle after address |

## Verification
The hardest case to reach is a read-after-write hazard inside the update loop. A word is read in the same cycle that its previous update is being written. The row memory meets this on every line. A column bank meets it only when a line is one batch wide. The bench steps through every width from one to eight batches and every height from one to thirty-two, so both hazard cases occur many times. It also inserts random idle cycles between batches, which splits back-to-back updates into gapped ones. Windows alternate between dense, empty and random patterns, so a large window with all pixels active can be followed by a smaller empty one, and any leftover count would show up.

// File: rtl/proj_hist_pkg.sv
// Shared types for the projection histogram accumulator.
package proj_hist_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_LOAD  = 2'd2
    } ph_state_e;
endpackage

// File: rtl/raster_coord_ctr.sv
// Raster position counter: x counts batches along a line, y counts lines.
// Assumes x_last/y_last stay constant while stepping; restart forces (0,0).
module raster_coord_ctr #(
    parameter int XW = 3,
    parameter int YW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    input  logic [XW-1:0] x_last,
    input  logic [YW-1:0] y_last,
    output logic [XW-1:0] x,
    output logic [YW-1:0] y,
    output logic          at_end
);
    // Flag the final batch of the window.
    assign at_end = (x == x_last) && (y == y_last);

    // Advance x each step; wrap x and advance y at line end.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            x <= '0;
            y <= '0;
        end else if (step) begin
            if (x == x_last) begin
                x <= '0;
                y <= (y == y_last) ? '0 : y + 1'b1;
            end else begin
                x <= x + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hist_bank.sv
// One histogram memory with a pipelined read-increment-write update port,
// a clear write port and a synchronous external read port.
// Assumes clear writes and updates never overlap in time. An update read
// that meets the write from the previous edge takes the forwarded value.
module hist_bank #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int DW    = 6,
    parameter int IW    = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_v,
    input  logic [AW-1:0] upd_addr,
    input  logic [IW-1:0] upd_inc,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_addr,
    input  logic [AW-1:0] ext_addr,
    output logic [DW-1:0] ext_data
);
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;
    logic          s_v;
    logic [AW-1:0] s_addr;
    logic [IW-1:0] s_inc;
    logic          wb_v;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;
    logic [DW-1:0] cur;
    logic [DW-1:0] nxt;
    logic          we;

    // Read stage: sample memory word and carry the update alongside it.
    always_ff @(posedge clk) begin
        rd_q   <= mem[upd_addr];
        s_addr <= upd_addr;
        s_inc  <= upd_inc;
        if (!rst_n) s_v <= 1'b0;
        else        s_v <= upd_v;
    end

    // Pick forwarded data when the previous write hit this word.
    always_comb begin
        cur = (wb_v && (wb_addr == s_addr)) ? wb_data : rd_q;
        nxt = cur + DW'(s_inc);
        we  = s_v && (s_inc != '0);
    end

    // Write stage: clear has priority, otherwise commit the increment.
    always_ff @(posedge clk) begin
        if (clr_en)  mem[clr_addr] <= '0;
        else if (we) mem[s_addr]   <= nxt;
    end

    // Remember the last committed write for forwarding.
    always_ff @(posedge clk) begin
        wb_addr <= s_addr;
        wb_data <= nxt;
        if (!rst_n) wb_v <= 1'b0;
        else        wb_v <= we;
    end

    // External synchronous read port.
    always_ff @(posedge clk) begin
        ext_data <= mem[ext_addr];
    end
endmodule

// File: rtl/proj_hist_acc.sv
// Projection histogram accumulator top. Sequences clear then load, keeps the
// raster position, updates LANES column banks and one row memory, and keeps
// the active total. Assumes LANES = 4, MAX_W a multiple of LANES and at
// least 2*LANES, and run-time sizes within 1..MAX_W/LANES and 1..MAX_H.
module proj_hist_acc
    import proj_hist_pkg::*;
#(
    parameter int MAX_W = 32,
    parameter int MAX_H = 32,
    parameter int LANES = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [$clog2(MAX_W/LANES+1)-1:0]       cfg_line_batches,
    input  logic [$clog2(MAX_H+1)-1:0]             cfg_height,
    input  logic                                   pix_valid,
    input  logic [LANES-1:0]                       pix_data,
    output logic                                   ready,
    output logic                                   done,
    output logic [$clog2(MAX_W*MAX_H+1)-1:0]       total,
    input  logic [$clog2(MAX_W)-1:0]               col_rd_addr,
    output logic [$clog2(MAX_H+1)-1:0]             col_rd_data,
    input  logic [$clog2(MAX_H)-1:0]               row_rd_addr,
    output logic [$clog2(MAX_W+1)-1:0]             row_rd_data
);
    localparam int BANK_D = MAX_W / LANES;
    localparam int XA_W   = $clog2(BANK_D);
    localparam int YA_W   = $clog2(MAX_H);
    localparam int LN_W   = $clog2(LANES);
    localparam int WB_W   = $clog2(BANK_D + 1);
    localparam int H_W    = $clog2(MAX_H + 1);
    localparam int COL_W  = $clog2(MAX_H + 1);
    localparam int ROW_W  = $clog2(MAX_W + 1);
    localparam int TOT_W  = $clog2(MAX_W * MAX_H + 1);
    localparam int POP_W  = $clog2(LANES + 1);
    localparam int CLR_W  = (WB_W > H_W) ? WB_W : H_W;

    ph_state_e        st;
    logic [WB_W-1:0]  wb_q;
    logic [H_W-1:0]   h_q;
    logic [CLR_W-1:0] clr_cnt;
    logic [CLR_W-1:0] clr_len;
    logic             start_ok;
    logic             accept;
    logic [XA_W-1:0]  cx;
    logic [YA_W-1:0]  cy;
    logic             at_end;
    logic [POP_W-1:0] pop;
    logic             s1_v;
    logic             s1_last;
    logic [POP_W-1:0] s1_pop;
    logic             done_q;
    logic [TOT_W-1:0] tot_q;
    logic             col_clr;
    logic             row_clr;
    logic [COL_W-1:0] col_q [LANES];
    logic [LN_W-1:0]  lane_q;

    // Control decodes.
    assign start_ok = (st == PH_IDLE) && start && !s1_v;
    assign ready    = (st == PH_LOAD);
    assign accept   = ready && pix_valid;
    assign clr_len  = (CLR_W'(wb_q) > CLR_W'(h_q)) ? CLR_W'(wb_q) : CLR_W'(h_q);
    assign col_clr  = (st == PH_CLEAR) && (CLR_W'(wb_q) > clr_cnt);
    assign row_clr  = (st == PH_CLEAR) && (CLR_W'(h_q) > clr_cnt);

    // Number of active lanes in the incoming batch.
    always_comb begin
        pop = '0;
        for (int k = 0; k < LANES; k++) pop = pop + POP_W'(pix_data[k]);
    end

    // Sequencer: idle -> clear (max(width,height) cycles) -> load -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PH_IDLE;
            clr_cnt <= '0;
            wb_q    <= WB_W'(1);
            h_q     <= H_W'(1);
        end else begin
            case (st)
                PH_IDLE: if (start_ok) begin
                    wb_q    <= cfg_line_batches;
                    h_q     <= cfg_height;
                    clr_cnt <= '0;
                    st      <= PH_CLEAR;
                end
                PH_CLEAR: begin
                    clr_cnt <= clr_cnt + 1'b1;
                    if (clr_cnt == clr_len - 1'b1) st <= PH_LOAD;
                end
                PH_LOAD: if (accept && at_end) st <= PH_IDLE;
                default: st <= PH_IDLE;
            endcase
        end
    end

    // Raster position of the batch on the input.
    raster_coord_ctr #(.XW(XA_W), .YW(YA_W)) u_coord (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_ok),
        .step    (accept),
        .x_last  (XA_W'(wb_q - 1'b1)),
        .y_last  (YA_W'(h_q - 1'b1)),
        .x       (cx),
        .y       (cy),
        .at_end  (at_end)
    );

    // Stage aligned with the memory read: carries last flag and popcount.
    always_ff @(posedge clk) begin
        s1_pop <= pop;
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_last <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            s1_v    <= accept;
            s1_last <= accept && at_end;
            done_q  <= s1_v && s1_last;
        end
    end

    // Active pixel total, cleared when a window starts.
    always_ff @(posedge clk) begin
        if (!rst_n || start_ok) tot_q <= '0;
        else if (s1_v)          tot_q <= tot_q + TOT_W'(s1_pop);
    end

    assign done  = done_q;
    assign total = tot_q;

    // One column bank per lane; lane pixel is the increment.
    for (genvar k = 0; k < LANES; k++) begin : g_col
        hist_bank #(.DEPTH(BANK_D), .AW(XA_W), .DW(COL_W), .IW(1)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .upd_v    (accept),
            .upd_addr (cx),
            .upd_inc  (pix_data[k]),
            .clr_en   (col_clr),
            .clr_addr (XA_W'(clr_cnt)),
            .ext_addr (col_rd_addr[LN_W +: XA_W]),
            .ext_data (col_q[k])
        );
    end

    // Row memory; increment is the lane popcount.
    hist_bank #(.DEPTH(MAX_H), .AW(YA_W), .DW(ROW_W), .IW(POP_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_v    (accept),
        .upd_addr (cy),
        .upd_inc  (pop),
        .clr_en   (row_clr),
        .clr_addr (YA_W'(clr_cnt)),
        .ext_addr (row_rd_addr),
        .ext_data (row_rd_data)
    );

    // Remember which lane the column read selected.
    always_ff @(posedge clk) begin
        lane_q <= col_rd_addr[LN_W-1:0];
    end

    assign col_rd_data = col_q[lane_q];
endmodule

// File: rtl/proj_hist_acc_chk.sv
// Port-level temporal checks for the projection histogram accumulator.
module proj_hist_acc_chk #(
    parameter int TOT_W   = 11,
    parameter int TOT_MAX = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ready,
    input logic             done,
    input logic             pix_valid,
    input logic [TOT_W-1:0] total
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ready); // R2
    AST_TOTAL_ZERO_AT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (total == '0)); // R1
    AST_TOTAL_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> (total >= $past(total))); // R6
    AST_TOTAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(total) <= TOT_MAX); // R6
    AST_START_IGNORED_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start && !pix_valid) |=> ready); // R10
endmodule

bind proj_hist_acc proj_hist_acc_chk #(
    .TOT_W   ($clog2(MAX_W*MAX_H+1)),
    .TOT_MAX (MAX_W*MAX_H)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (ready),
    .done      (done),
    .pix_valid (pix_valid),
    .total     (total)
);

// File: tb/proj_hist_acc_bench.sv
// Sweeps every window size of the default configuration with several pixel
// patterns and random gaps, modelling counts arithmetically.
module proj_hist_acc_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  cfg_line_batches;
    logic [5:0]  cfg_height;
    logic        pix_valid;
    logic [3:0]  pix_data;
    logic        ready;
    logic        done;
    logic [10:0] total;
    logic [4:0]  col_rd_addr;
    logic [5:0]  col_rd_data;
    logic [4:0]  row_rd_addr;
    logic [5:0]  row_rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    int col_exp [32];
    int row_exp [32];
    int tot_exp;

    always #5 clk = ~clk;

    proj_hist_acc u_proj_hist_acc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_line_batches(cfg_line_batches), .cfg_height(cfg_height),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .ready(ready), .done(done), .total(total),
        .col_rd_addr(col_rd_addr), .col_rd_data(col_rd_data),
        .row_rd_addr(row_rd_addr), .row_rd_data(row_rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic [3:0] pattern(input int mode, input int b);
        case (mode)
            0: return 4'hF;
            1: return 4'h0;
            2: return lfsr[3:0];
            3: return (b % 2 == 0) ? 4'h5 : 4'hA;
            default: return lfsr[3:0] & lfsr[7:4];
        endcase
    endfunction

    task automatic run_window(input int wb, input int h, input int mode);
        int n;
        int lim;
        int b;
        int nb;
        bit v;
        logic [3:0] d;
        @(negedge clk);
        cfg_line_batches = 4'(wb);
        cfg_height = 6'(h);
        start = 1'b1;
        pix_valid = 1'b1;          // R9: pixels during clear must be ignored
        pix_data = 4'hF;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        lim = (wb > h) ? wb : h;
        while (ready !== 1'b1 && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk("R1 clear cycles", n, lim);
        chk("R1 total zero at open", int'(total), 0);
        for (int i = 0; i < 32; i++) begin
            col_exp[i] = 0;
            row_exp[i] = 0;
        end
        tot_exp = 0;
        nb = wb * h;
        b = 0;
        while (b < nb) begin
            step_lfsr();
            v = !((mode >= 2) && (lfsr[11:9] == 3'd0));
            d = v ? pattern(mode, b) : 4'hF;
            pix_valid = v;
            pix_data = d;
            start = (b == 1) && v;   // R10: ignored while loading
            if (v) begin
                for (int k = 0; k < 4; k++) begin
                    if (d[k]) begin
                        col_exp[4 * (b % wb) + k]++;
                        row_exp[b / wb]++;
                        tot_exp++;
                    end
                end
            end
            @(posedge clk);
            if (v) b++;
            @(negedge clk);
            start = 1'b0;
            if (b < nb) chk("R2 R10 ready while loading", int'(ready), 1);
        end
        pix_valid = 1'b1;            // R9: pixels in idle must be ignored
        pix_data = 4'hF;
        chk("R2 ready low after last", int'(ready), 0);
        chk("R3 done not yet", int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        pix_valid = 1'b0;
        chk("R3 done pulse", int'(done), 1);
        chk("R6 total", int'(total), tot_exp);
        @(posedge clk);
        @(negedge clk);
        chk("R3 done single cycle", int'(done), 0);
        for (int c = 0; c < 4 * wb; c++) begin
            col_rd_addr = 5'(c);
            @(posedge clk);
            @(negedge clk);
            if (wb == 1)        chk("R7 column same-word", int'(col_rd_data), col_exp[c]);
            else if (mode == 1) chk("R8 column no leftover", int'(col_rd_data), col_exp[c]);
            else                chk("R4 column count", int'(col_rd_data), col_exp[c]);
        end
        for (int r = 0; r < h; r++) begin
            row_rd_addr = 5'(r);
            @(posedge clk);
            @(negedge clk);
            if (mode == 1) chk("R8 row no leftover", int'(row_rd_data), row_exp[r]);
            else           chk("R5 R7 row count", int'(row_rd_data), row_exp[r]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        cfg_line_batches = 4'd1;
        cfg_height = 6'd1;
        pix_valid = 1'b0;
        pix_data = 4'h0;
        col_rd_addr = '0;
        row_rd_addr = '0;
        repeat (3) @(negedge clk);
        chk("R11 reset ready", int'(ready), 0);
        chk("R11 reset done", int'(done), 0);
        chk("R11 reset total", int'(total), 0);
        rst_n = 1'b1;
        // Large dense window, then a small empty one (R8)
        run_window(8, 32, 0);
        run_window(2, 3, 1);
        for (int wb = 1; wb <= 8; wb++) begin
            for (int h = 1; h <= 32; h++) begin
                run_window(wb, h, (wb + h) % 5);
            end
        end
        summary();
    end
endmodule